// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block makes the timing strobes for a UART. The system clock first passes through an optional divide-by-4 prescaler, which produces a clock enable. A period counter then divides that enable by a programmable divisor. The divisor has a 16-bit integer part and a 4-bit fraction in sixteenths. The result is a one-cycle sampling strobe at 16, 8 or 4 times the serial bit rate. A second counter groups those strobes into a one-cycle bit-rate strobe. The fraction works through a 4-bit phase accumulator. Each time a sampling period ends, the fractional code is added to the accumulator. A carry out makes the current period one prescaled clock longer, so over sixteen periods the average divisor is exactly integer + code/16.

Software programs the generator through a small byte-wide write port that has five register selects:

| Select | Register | Contents |
|--------|----------|----------|
| 0 | Line control | Bit 0 is the divisor access enable |
| 1 | Mode | Bit 0 = prescale by 4, bit 1 = 8X, bit 2 = 4X |
| 2 | Divisor low byte | Low 8 bits of the integer part |
| 3 | Divisor high byte | High 8 bits of the integer part |
| 4 | Divisor fraction | Bits 3:0 are the fraction in sixteenths |

Any accepted write to a divisor register or to the mode register restarts all of the dividers from zero.

Top module: `frac_baud_gen`

## Requirements
- R1: When mode bit 0 is 1, every sampling period is four times as long in system clocks as with bit 0 at 0. The divider then advances only once per four system clocks.
- R2: The integer divisor is {high byte, low byte}, taken from selects 3 and 2. With fraction 0, each sampling period is that many prescaled clocks, including values above 255.
- R3: With integer part I and fraction F (select 4, bits 3:0), every sampling period is I or I+1 prescaled clocks. Any 16 consecutive periods sum to exactly 16*I+F prescaled clocks.
- R4: Writes to selects 2, 3 and 4 while line-control bit 0 is 0 change neither the divisor nor the tick timing.
- R5: After reset the divisor is 1 with fraction 0, the prescaler is off and 16X mode is selected. The sampling strobe is therefore high on every cycle, and the bit strobe comes every 16 cycles. Both strobes are low while reset is asserted.
- R6: An integer part of 0 acts as 1.
- R7: The bit strobe fires once per 16 sampling strobes when mode bits 2:1 are 00, and once per 8 when they are 01. It fires once per 4 when bit 2 is set, whatever the value of bit 1. It is high only together with a sampling strobe.
- R8: An accepted divisor or mode write on clock edge E clears the period counter, the accumulator and the oversample counter. With the prescaler off, the first sampling strobe is high in the cycle after edge E+I. The first bit strobe coincides with the 16th, 8th or 4th sampling strobe after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_sel | input | 3 | Register select: 0 line control, 1 mode, 2 divisor low, 3 divisor high, 4 fraction |
| cfg_wdata | input | 8 | Write data |
| sample_tick | output | 1 | One-cycle sampling strobe at 16X/8X/4X the bit rate |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The bench sweeps all sixteen fractional codes with integer parts 0, 1, 2, 3 and 5, with the prescaler both off and on. For each setting it checks three things:
- the summed length of sixteen periods, which separates every fractional code from its neighbours;
- the shortest and longest single period, which exposes a carry applied in the wrong amount or to the wrong period;
- the delay from the restarting write to the first strobe.

Divisors of 256 and 258 exercise the high byte. The four mode codes, including both bits set, are checked by the spacing of the bit strobes and by the index of the first bit strobe. Writes made while access is closed are followed by a timing measurement that shows the old divisor still in force.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;

  localparam int unsigned CFG_SEL_W  = 3;
  localparam int unsigned CFG_DATA_W = 8;

  localparam int unsigned LINE_ACCESS_BIT = 0;
  localparam int unsigned MODE_PRE_BIT    = 0;
  localparam int unsigned MODE_8X_BIT     = 1;
  localparam int unsigned MODE_4X_BIT     = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_LINE     = 3'd0,
    SEL_MODE     = 3'd1,
    SEL_DIV_LO   = 3'd2,
    SEL_DIV_HI   = 3'd3,
    SEL_DIV_FRAC = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    OVS_16X = 2'd0,
    OVS_8X  = 2'd1,
    OVS_4X  = 2'd2
  } ovs_mode_e;

  // 4X wins when both mode bits are set
  function automatic ovs_mode_e decode_ovs(input logic b8, input logic b4);
    if (b4) return OVS_4X;
    if (b8) return OVS_8X;
    return OVS_16X;
  endfunction

endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we_i,
  input  logic [CFG_SEL_W-1:0]  cfg_sel_i,
  input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
  output logic [INT_W-1:0]      int_div_o,
  output logic [FRAC_W-1:0]     frac_o,
  output logic                  pre_sel_o,
  output ovs_mode_e             ovs_mode_o,
  output logic                  clr_o
);

  localparam int unsigned LO_W = CFG_DATA_W;
  localparam int unsigned HI_W = INT_W - LO_W;

  cfg_sel_e sel_w;
  logic     line_we, mode_we, lo_we, hi_we, frac_we;

  logic              access_q;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic              pre_q;
  ovs_mode_e         mode_q;

  logic              access_d;
  logic [LO_W-1:0]   lo_d;
  logic [HI_W-1:0]   hi_d;
  logic [FRAC_W-1:0] frac_d;
  logic              pre_d;
  ovs_mode_e         mode_d;

  // write decode: divisor registers are gated by the access bit
  always_comb begin
    sel_w   = cfg_sel_e'(cfg_sel_i);
    line_we = cfg_we_i && (sel_w == SEL_LINE);
    mode_we = cfg_we_i && (sel_w == SEL_MODE);
    lo_we   = cfg_we_i && access_q && (sel_w == SEL_DIV_LO);
    hi_we   = cfg_we_i && access_q && (sel_w == SEL_DIV_HI);
    frac_we = cfg_we_i && access_q && (sel_w == SEL_DIV_FRAC);
  end

  always_comb begin
    access_d = cfg_wdata_i[LINE_ACCESS_BIT];
    lo_d     = cfg_wdata_i[LO_W-1:0];
    hi_d     = cfg_wdata_i[HI_W-1:0];
    frac_d   = cfg_wdata_i[FRAC_W-1:0];
    pre_d    = cfg_wdata_i[MODE_PRE_BIT];
    mode_d   = decode_ovs(cfg_wdata_i[MODE_8X_BIT], cfg_wdata_i[MODE_4X_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_q <= 1'b0;
      lo_q     <= LO_W'(1);
      hi_q     <= '0;
      frac_q   <= '0;
      pre_q    <= 1'b0;
      mode_q   <= OVS_16X;
    end else begin
      if (line_we) access_q <= access_d;
      if (lo_we)   lo_q     <= lo_d;
      if (hi_we)   hi_q     <= hi_d;
      if (frac_we) frac_q   <= frac_d;
      if (mode_we) begin
        pre_q  <= pre_d;
        mode_q <= mode_d;
      end
    end
  end

  assign int_div_o  = {hi_q, lo_q};
  assign frac_o     = frac_q;
  assign pre_sel_o  = pre_q;
  assign ovs_mode_o = mode_q;
  assign clr_o      = lo_we || hi_we || frac_we || mode_we;

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !access_q) |=> ($stable(lo_q) && $stable(hi_q) && $stable(frac_q))); // R4

endmodule

// File: rtl/fbg_prescale.sv
`timescale 1ns/1ps
module fbg_prescale #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic pre_sel_i,
  output logic en_o
);

  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [CW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    if (clr_i || !pre_sel_i)
      pcnt_d = '0;
    else if (pcnt_q == CW'(RATIO - 1))
      pcnt_d = '0;
    else
      pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign en_o = !pre_sel_i || (pcnt_q == '0);

  generate
    if (RATIO > 1) begin : g_gap_chk
      AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel_i && en_o && !clr_i) |=> (!en_o || !pre_sel_i)); // R1
    end
  endgenerate

endmodule

// File: rtl/fbg_divider.sv
`timescale 1ns/1ps
module fbg_divider #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [INT_W-1:0]  int_div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);

  logic [INT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic              tick_q, tick_d;

  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;
  logic [INT_W-1:0]  last_idx;
  logic              at_last;
  logic              wrap;

  // period length = max(int,1) + carry of this period's accumulation
  always_comb begin
    int_eff  = (int_div_i == '0) ? INT_W'(1) : int_div_i;
    acc_sum  = {1'b0, acc_q} + {1'b0, frac_i};
    carry    = acc_sum[FRAC_W];
    last_idx = int_eff - INT_W'(1) + {{(INT_W-1){1'b0}}, carry};
    at_last  = (cnt_q == last_idx);
    wrap     = step_i && at_last;
  end

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (wrap)   cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;

    if (clr_i)     acc_d = '0;
    else if (wrap) acc_d = acc_sum[FRAC_W-1:0];
    else           acc_d = acc_q;

    tick_d = wrap && !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx); // R3
  AST_ACC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(step_i && at_last)) |=> $stable(acc_q)); // R3
  AST_TICK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(step_i)); // R1

endmodule

// File: rtl/fbg_oversample.sv
`timescale 1ns/1ps
module fbg_oversample
  import fbg_pkg::*;
#(
  parameter int unsigned OS_MAX = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      sample_i,
  input  ovs_mode_e mode_i,
  output logic      bit_o
);

  localparam int unsigned CW = $clog2(OS_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] os_last;
  logic          at_last;

  always_comb begin
    case (mode_i)
      OVS_16X: os_last = CW'(OS_MAX - 1);
      OVS_8X:  os_last = CW'(OS_MAX / 2 - 1);
      default: os_last = CW'(OS_MAX / 4 - 1);
    endcase
    at_last = (cnt_q == os_last);
  end

  always_comb begin
    if (clr_i)                cnt_d = '0;
    else if (sample_i && at_last) cnt_d = '0;
    else if (sample_i)        cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_o = sample_i && at_last;

  AST_OS_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= os_last); // R7

endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W     = 16,
  parameter int unsigned FRAC_W    = 4,
  parameter int unsigned PRE_RATIO = 4,
  parameter int unsigned OS_MAX    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic       sample_tick,
  output logic       bit_tick
);

  localparam int unsigned CHK_W = $clog2(OS_MAX) + 1;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [INT_W-1:0]  int_div;
  logic [FRAC_W-1:0] frac;
  logic              pre_sel;
  ovs_mode_e         ovs_mode;
  logic              clr;
  logic              step;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fbg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we_i   (cfg_we),
    .cfg_sel_i  (cfg_sel),
    .cfg_wdata_i(cfg_wdata),
    .int_div_o  (int_div),
    .frac_o     (frac),
    .pre_sel_o  (pre_sel),
    .ovs_mode_o (ovs_mode),
    .clr_o      (clr)
  );

  fbg_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr),
    .pre_sel_i(pre_sel),
    .en_o     (step)
  );

  fbg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr),
    .step_i   (step),
    .int_div_i(int_div),
    .frac_i   (frac),
    .tick_o   (sample_tick)
  );

  fbg_oversample #(.OS_MAX(OS_MAX)) u_ovs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (clr),
    .sample_i(sample_tick),
    .mode_i  (ovs_mode),
    .bit_o   (bit_tick)
  );

  // spacing checker: independent count of sampling strobes per bit strobe
  logic [CHK_W-1:0] chk_cnt_q;
  logic [CHK_W-1:0] chk_need;

  always_comb begin
    case (ovs_mode)
      OVS_16X: chk_need = CHK_W'(OS_MAX - 1);
      OVS_8X:  chk_need = CHK_W'(OS_MAX / 2 - 1);
      default: chk_need = CHK_W'(OS_MAX / 4 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      chk_cnt_q <= '0;
    else if (clr)         chk_cnt_q <= '0;
    else if (bit_tick)    chk_cnt_q <= '0;
    else if (sample_tick) chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |-> (chk_cnt_q == chk_need)); // R7

endmodule

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       sample_tick, bit_tick;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int ivals[5] = '{0, 1, 2, 3, 5};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .sample_tick(sample_tick),
    .bit_tick   (bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = 3'(sel);
    cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic program_cfg(input int pre, input int mode_bits,
                             input int intv, input int frac);
    cfg_write(0, 1);
    cfg_write(2, intv & 8'hFF);
    cfg_write(3, (intv >> 8) & 8'hFF);
    cfg_write(4, frac);
    cfg_write(0, 0);
    cfg_write(1, mode_bits | pre);
  endtask

  // observe n+1 sampling strobes after the current cycle
  task automatic run_window(input int n, output int lat, output int sum,
                            output int mn, output int mx,
                            output int first_bit, output int bit_gap);
    int t0, prev, first, k, b0;
    t0 = cyc; prev = 0; first = 0; k = 0; b0 = 0;
    lat = -1; mn = 1 << 30; mx = 0; first_bit = -1; bit_gap = -1;
    while (k <= n) begin
      @(negedge clk);
      if (sample_tick) begin
        if (k == 0) begin
          lat = cyc - t0;
          first = cyc;
        end else begin
          if (cyc - prev < mn) mn = cyc - prev;
          if (cyc - prev > mx) mx = cyc - prev;
        end
        if (bit_tick) begin
          if (first_bit < 0) begin
            first_bit = k + 1;
            b0 = cyc;
          end else if (bit_gap < 0) begin
            bit_gap = cyc - b0;
          end
        end
        prev = cyc;
        k++;
      end
    end
    sum = prev - first;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, sum, mn, mx, fb, bg;
    int modes[4] = '{0, 2, 4, 6};
    int nexp[4]  = '{16, 8, 4, 4};

    repeat (3) @(negedge clk);
    check(!sample_tick && !bit_tick, "R5", "strobes during reset",
          int'(sample_tick) + int'(bit_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: default divisor 1, 16X
    run_window(40, lat, sum, mn, mx, fb, bg);
    check(mn == 1 && mx == 1, "R5", "default sampling period", mx, 1);
    check(bg == 16, "R5", "default bit strobe spacing", bg, 16);

    // R1 R3 R6 R8: fraction sweep
    for (int p = 0; p < 2; p++) begin
      for (int ii = 0; ii < 5; ii++) begin
        for (int f = 0; f < 16; f++) begin
          int iv, ie, pm, exp_sum, hi_len;
          string req;
          iv = ivals[ii];
          ie = (iv == 0) ? 1 : iv;
          pm = (p != 0) ? 4 : 1;
          req = (iv == 0) ? "R6" : ((p != 0) ? "R1" : "R3");
          exp_sum = pm * (16 * ie + f);
          hi_len = (f != 0) ? (ie + 1) * pm : ie * pm;
          program_cfg(p, 0, iv, f);
          run_window(16, lat, sum, mn, mx, fb, bg);
          check(sum == exp_sum, req, "sum of 16 sampling periods", sum, exp_sum);
          check(mn >= ie * pm, req, "shortest sampling period", mn, ie * pm);
          check(mx <= hi_len, req, "longest sampling period", mx, hi_len);
          if (p == 0) check(lat == ie, "R8", "first strobe after write", lat, ie);
        end
      end
    end

    // R2: high byte in use
    program_cfg(0, 0, 258, 3);
    run_window(16, lat, sum, mn, mx, fb, bg);
    check(sum == 16 * 258 + 3, "R2", "divisor 258+3/16 sum", sum, 16 * 258 + 3);
    check(lat == 258, "R8", "first strobe divisor 258", lat, 258);
    program_cfg(0, 0, 256, 0);
    run_window(4, lat, sum, mn, mx, fb, bg);
    check(mn == 256 && mx == 256, "R2", "divisor 256 period", mx, 256);

    // R7 R8: oversampling modes
    for (int m = 0; m < 4; m++) begin
      program_cfg(0, modes[m], 2, 0);
      run_window(2 * nexp[m], lat, sum, mn, mx, fb, bg);
      check(fb == nexp[m], "R8", "first bit strobe index", fb, nexp[m]);
      check(bg == 2 * nexp[m], "R7", "bit strobe spacing", bg, 2 * nexp[m]);
    end
    program_cfg(1, 2, 3, 0);
    run_window(16, lat, sum, mn, mx, fb, bg);
    check(bg == 8 * 3 * 4, "R7", "8X with prescaler bit spacing", bg, 96);

    // R4: locked writes have no effect
    program_cfg(0, 0, 3, 0);
    cfg_write(2, 9);
    cfg_write(3, 1);
    cfg_write(4, 5);
    run_window(16, lat, sum, mn, mx, fb, bg);
    check(sum == 48, "R4", "sum after locked writes", sum, 48);
    check(mn == 3 && mx == 3, "R4", "period after locked writes", mx, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule